// File: doc/BRIEF.md
# Windowed Input Time Accumulator

This block measures how long a digital input spends at a chosen level inside a time window. The window is defined against a free-running timebase that the block receives from outside. Two programmable registers set the window: an open value and a close value. When the timebase equals the open value, an accumulator is cleared and starts counting. From then on it advances at a prescaled rate, but only on cycles where the synchronized input matches a polarity setting.

When the timebase equals the close value, counting stops no matter what the input is doing. At that edge the accumulated total is copied into a capture register and a sticky done flag is raised. Software reads either register to get the measured high or low time. It clears the flag with a pulse.

Top module: `wita_top`

## Requirements
- R1: After reset, `acc_q`, `cap_q` and `flag` are all zero and no window is open.
- R2: A write strobe (`open_we`, `close_we`) loads the matching register from its data port in the same clock. The open match (timebase equal to the open register) clears `acc_q` and opens the window. It leaves `flag` unchanged.
- R3: While the window is open, `acc_q` increments on a prescaler tick only when the synchronized input equals `pol`. With `pol`=1 it measures high time; with `pol`=0 it measures low time. On all other cycles it holds.
- R4: The close match, while a window is open, closes the window and copies `acc_q` into `cap_q`. It also sets `flag` in the same clock. From then on `acc_q` holds.
- R5: `pre_sel` value k (0..3) gives one tick every k+1 clocks. The tick phase restarts at the open match, so N open-window clocks yield floor(N/(k+1)) increments.
- R6: `sig_in` passes through two flip-flops before it is compared with `pol`. A pulse of K clocks therefore adds exactly K counts at `pre_sel`=0.
- R7: If the open and close registers hold the same value, the close match wins at that timebase value. `cap_q` and `acc_q` become zero, `flag` is set and the window stays closed.
- R8: `acc_q` saturates at its all-ones value instead of wrapping.
- R9: `flag` stays set until a `flag_clr` pulse clears it. A close match in the same clock as `flag_clr` leaves `flag` set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| timebase | input | TB_W | Free-running external timebase |
| sig_in | input | 1 | Asynchronous measured input |
| open_we | input | 1 | Write strobe for the window open register |
| open_wdata | input | TB_W | Window open value |
| close_we | input | 1 | Write strobe for the window close register |
| close_wdata | input | TB_W | Window close value |
| pre_sel | input | 2 | Prescaler select: tick every pre_sel+1 clocks |
| pol | input | 1 | Level that is counted (1 high, 0 low) |
| flag_clr | input | 1 | Pulse that clears the done flag |
| acc_q | output | ACC_W | Running accumulator |
| cap_q | output | ACC_W | Value captured at window close |
| flag | output | 1 | Sticky window-done flag |

## Verification
The bench builds the block with TB_W=8 and ACC_W=4. An 8-bit timebase wraps every 256 clocks, so a window that straddles the wrap point can be reached within a few hundred cycles. A 4-bit accumulator saturates after fifteen counts, so a sixty-clock window reaches its ceiling. This keeps every prescaler setting, both polarities, equal open and close values, and the set-beats-clear case inside short runs.

// File: rtl/wita_pkg.sv
package wita_pkg;

  typedef enum logic {
    WIN_SHUT = 1'b0,
    WIN_OPEN = 1'b1
  } win_state_e;

  localparam int unsigned PRE_W = 2;

endpackage

// File: rtl/wita_sync.sv
module wita_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_async,
  output logic d_sync
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d_async};
  end

  assign d_sync = chain[STAGES-1];

endmodule

// File: rtl/wita_prescale.sv
module wita_prescale #(
  parameter int unsigned SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             run,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);

  logic [SEL_W-1:0] phase;

  assign tick = run && (phase == sel);

  always_ff @(posedge clk) begin
    if (rst || restart)  phase <= '0;
    else if (run)        phase <= tick ? '0 : phase + 1'b1;
  end

  // R5
  phase_range_chk: assert property (@(posedge clk) disable iff (rst)
    run && !restart && $stable(sel) |-> phase <= sel);

endmodule

// File: rtl/wita_match.sv
module wita_match #(
  parameter int unsigned TB_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [TB_W-1:0] timebase,
  input  logic            open_we,
  input  logic [TB_W-1:0] open_wdata,
  input  logic            close_we,
  input  logic [TB_W-1:0] close_wdata,
  output logic            open_hit,
  output logic            close_hit
);

  logic [TB_W-1:0] open_r;
  logic [TB_W-1:0] close_r;

  always_ff @(posedge clk) begin
    if (rst) begin
      open_r  <= '0;
      close_r <= '0;
    end else begin
      if (open_we)  open_r  <= open_wdata;
      if (close_we) close_r <= close_wdata;
    end
  end

  assign open_hit  = (timebase == open_r);
  assign close_hit = (timebase == close_r);

  // R2
  open_load_chk: assert property (@(posedge clk) disable iff (rst)
    open_we |=> open_r == $past(open_wdata));

endmodule

// File: rtl/wita_window.sv
module wita_window
  import wita_pkg::*;
#(
  parameter int unsigned ACC_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             open_hit,
  input  logic             close_hit,
  input  logic             tick,
  input  logic             level,
  input  logic             pol,
  input  logic             flag_clr,
  output logic             win_open,
  output logic [ACC_W-1:0] acc_q,
  output logic [ACC_W-1:0] cap_q,
  output logic             flag
);

  localparam logic [ACC_W-1:0] ACC_MAX = {ACC_W{1'b1}};

  win_state_e state;
  logic       close_ev;
  logic       count_en;

  assign win_open = (state == WIN_OPEN);
  assign close_ev = close_hit && (win_open || open_hit);
  assign count_en = win_open && tick && (level == pol);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= WIN_SHUT;
      acc_q <= '0;
      cap_q <= '0;
    end else if (close_ev) begin
      state <= WIN_SHUT;
      cap_q <= open_hit ? '0 : acc_q;
      if (open_hit) acc_q <= '0;
    end else if (open_hit) begin
      state <= WIN_OPEN;
      acc_q <= '0;
    end else if (count_en && acc_q != ACC_MAX) begin
      acc_q <= acc_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)           flag <= 1'b0;
    else if (close_ev) flag <= 1'b1;
    else if (flag_clr) flag <= 1'b0;
  end

  // R4
  close_capture_chk: assert property (@(posedge clk) disable iff (rst)
    close_hit && win_open && !open_hit |=> cap_q == $past(acc_q) && flag && !win_open);

  // R8
  no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    !open_hit |=> acc_q >= $past(acc_q));

  // R3
  shut_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !win_open && !open_hit |=> $stable(acc_q));

  // R9
  flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    flag && !flag_clr |=> flag);

  // R7
  equal_match_chk: assert property (@(posedge clk) disable iff (rst)
    open_hit && close_hit |=> cap_q == '0 && flag && !win_open);

endmodule

// File: rtl/wita_top.sv
module wita_top
  import wita_pkg::*;
#(
  parameter int unsigned TB_W  = 16,
  parameter int unsigned ACC_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [TB_W-1:0]  timebase,
  input  logic             sig_in,
  input  logic             open_we,
  input  logic [TB_W-1:0]  open_wdata,
  input  logic             close_we,
  input  logic [TB_W-1:0]  close_wdata,
  input  logic [PRE_W-1:0] pre_sel,
  input  logic             pol,
  input  logic             flag_clr,
  output logic [ACC_W-1:0] acc_q,
  output logic [ACC_W-1:0] cap_q,
  output logic             flag
);

  logic level;
  logic open_hit;
  logic close_hit;
  logic tick;
  logic win_open;

  wita_sync #(.STAGES(2)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .d_async (sig_in),
    .d_sync  (level)
  );

  wita_match #(.TB_W(TB_W)) u_match (
    .clk         (clk),
    .rst         (rst),
    .timebase    (timebase),
    .open_we     (open_we),
    .open_wdata  (open_wdata),
    .close_we    (close_we),
    .close_wdata (close_wdata),
    .open_hit    (open_hit),
    .close_hit   (close_hit)
  );

  wita_prescale #(.SEL_W(PRE_W)) u_pre (
    .clk     (clk),
    .rst     (rst),
    .restart (open_hit),
    .run     (win_open),
    .sel     (pre_sel),
    .tick    (tick)
  );

  wita_window #(.ACC_W(ACC_W)) u_win (
    .clk       (clk),
    .rst       (rst),
    .open_hit  (open_hit),
    .close_hit (close_hit),
    .tick      (tick),
    .level     (level),
    .pol       (pol),
    .flag_clr  (flag_clr),
    .win_open  (win_open),
    .acc_q     (acc_q),
    .cap_q     (cap_q),
    .flag      (flag)
  );

endmodule

// File: tb/wita_top_tb_top.sv
module wita_top_tb_top;

  localparam int unsigned TB_W  = 8;
  localparam int unsigned ACC_W = 4;
  localparam int unsigned NVEC  = 10;

  typedef struct packed {
    logic [1:0]       pre;
    logic             pol;
    logic             lvl;
    logic [TB_W-1:0]  op;
    logic [TB_W-1:0]  cl;
    logic [ACC_W-1:0] exp;
  } vec_t;

  // pre, pol, level, open, close, expected count
  localparam vec_t VEC [NVEC] = '{
    '{2'd0, 1'b1, 1'b1, 8'd10,  8'd20,  4'd9},   // R3 high time
    '{2'd0, 1'b1, 1'b0, 8'd40,  8'd50,  4'd0},   // R3 no match, R2 clear
    '{2'd0, 1'b0, 1'b0, 8'd60,  8'd70,  4'd9},   // R3 low time
    '{2'd1, 1'b1, 1'b1, 8'd80,  8'd91,  4'd5},   // R5 div 2
    '{2'd2, 1'b1, 1'b1, 8'd100, 8'd110, 4'd3},   // R5 div 3
    '{2'd3, 1'b0, 1'b0, 8'd120, 8'd133, 4'd3},   // R5 div 4
    '{2'd0, 1'b1, 1'b1, 8'd140, 8'd200, 4'd15},  // R8 saturate
    '{2'd3, 1'b1, 1'b1, 8'd210, 8'd215, 4'd1},   // R5 short window
    '{2'd0, 1'b1, 1'b1, 8'd230, 8'd230, 4'd0},   // R7 equal values
    '{2'd0, 1'b1, 1'b1, 8'd250, 8'd5,   4'd10}   // R4 across wrap
  };

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [TB_W-1:0]  timebase = '0;
  logic             sig_in = 1'b0;
  logic             open_we = 1'b0;
  logic [TB_W-1:0]  open_wdata = '0;
  logic             close_we = 1'b0;
  logic [TB_W-1:0]  close_wdata = '0;
  logic [1:0]       pre_sel = '0;
  logic             pol = 1'b1;
  logic             flag_clr = 1'b0;
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] cap_q;
  logic             flag;

  int n_run  = 0;
  int n_fail = 0;
  int cyc    = 0;

  always #10 clk = ~clk;

  always @(negedge clk) if (!rst) timebase <= timebase + 1'b1;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: act=%0d cycles exp=<150000", cyc);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  wita_top #(.TB_W(TB_W), .ACC_W(ACC_W)) dut_i (
    .clk         (clk),
    .rst         (rst),
    .timebase    (timebase),
    .sig_in      (sig_in),
    .open_we     (open_we),
    .open_wdata  (open_wdata),
    .close_we    (close_we),
    .close_wdata (close_wdata),
    .pre_sel     (pre_sel),
    .pol         (pol),
    .flag_clr    (flag_clr),
    .acc_q       (acc_q),
    .cap_q       (cap_q),
    .flag        (flag)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic set_window(input logic [TB_W-1:0] o, input logic [TB_W-1:0] c);
    step();
    open_we = 1'b1; open_wdata = o;
    close_we = 1'b1; close_wdata = c;
    step();
    open_we = 1'b0; close_we = 1'b0;
  endtask

  task automatic pulse_clr();
    flag_clr = 1'b1;
    step();
    flag_clr = 1'b0;
  endtask

  task automatic wait_flag(input string req);
    int guard = 0;
    while (flag !== 1'b1 && guard < 700) begin
      step();
      guard++;
    end
    chk(req, guard < 700, 1);
  endtask

  task automatic wait_tb(input logic [TB_W-1:0] v);
    int guard = 0;
    while (timebase != v && guard < 300) begin
      step();
      guard++;
    end
  endtask

  initial begin
    // R1 reset state
    repeat (3) step();
    rst = 1'b0;
    chk("R1 acc", acc_q, 0);
    chk("R1 cap", cap_q, 0);
    chk("R1 flag", flag, 0);

    for (int i = 0; i < NVEC; i++) begin
      pre_sel = VEC[i].pre;
      pol     = VEC[i].pol;
      sig_in  = VEC[i].lvl;
      set_window(VEC[i].op, VEC[i].cl);
      pulse_clr();
      chk("R9 cleared", flag, 0);
      wait_flag("R4 flag");
      chk("R4 cap", cap_q, VEC[i].exp);
      chk("R4 acc hold", acc_q, VEC[i].exp);
    end

    // R2: re-arm clears acc but leaves flag set; level 0 so nothing counts
    sig_in = 1'b0; pol = 1'b1; pre_sel = 2'd0;
    set_window(8'd40, 8'd60);
    wait_tb(8'd43);
    chk("R2 acc cleared", acc_q, 0);
    chk("R2 flag kept", flag, 1);
    // R6: 7-clock pulse inside window counts 7
    wait_tb(8'd45);
    sig_in = 1'b1;
    repeat (7) step();
    sig_in = 1'b0;
    pulse_clr();
    wait_flag("R6 flag");
    chk("R6 pulse count", cap_q, 7);

    // R9: clear in the same clock as close match leaves flag set
    set_window(8'd90, 8'd100);
    pulse_clr();
    chk("R9 clear", flag, 0);
    wait_tb(8'd100);
    flag_clr = 1'b1;
    step();
    flag_clr = 1'b0;
    chk("R9 set wins", flag, 1);
    step();
    chk("R9 sticky", flag, 1);
    pulse_clr();
    chk("R9 clear pulse", flag, 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule